// File: doc/BRIEF.md
# Dual-Channel Transmit Status Register

This block keeps the transmit health of two independent channels, A and B, and presents it to a host as one 8-bit status byte. Each channel owns a one-entry sample holding register. The serial side fills it with a signed 20-bit word. A per-channel sample tick drains it into a 16-bit output stage that clips values outside the 16-bit signed range. When a tick arrives and nothing is held, the channel keeps driving its previous output sample and records an underrun.

For each channel the status byte carries three flags. The clip (saturation) flag and the underrun flag are sticky and clear when the host reads the status byte. The idle bit follows the channel's idle input live. A write-only mask register selects which status bits drive a single summary output, so a host can poll one line instead of the whole byte. The host interface is a single-cycle read or write strobe with an address. Read data is combinational while the read strobe is high.

Top module: `txs_status_top`

## Requirements
- R1: After reset, with both idle inputs high, the status byte reads 0x11, the mask register holds 0 and the summary output is low.
- R2: Status byte layout: bit 6 is B clip, bit 5 is B underrun, bit 4 is B idle, bit 2 is A clip, bit 1 is A underrun and bit 0 is A idle. Bits 7 and 3 always read 0.
- R3: A tick that finds a held sample updates that channel's 16-bit output at the next clock edge. Inputs above +32767 give 0x7FFF, inputs below -32768 give 0x8000, and all other inputs pass through unchanged.
- R4: The clip flag is set only when the clip stage actually altered the value. Inputs of exactly +32767 or -32768 do not set it.
- R5: A tick with no held sample sets the underrun flag and leaves the channel's output sample unchanged.
- R6: Clip and underrun flags stay set until a read of the status address (0x10). That read returns the value from before the clear, and the flags are 0 from the next cycle. A read at any other address clears nothing.
- R7: If a flag event coincides with a clearing status read, the flag is 1 after that cycle.
- R8: Each idle bit equals its channel's idle input in the same cycle, with no latching.
- R9: The summary output is high exactly when some status bit and its mask bit are both 1. The mask is written at address 0x11. Writes to mask bits 7 and 3 are dropped. A read at the mask address returns 0.
- R10: A load and a tick on the same channel in the same cycle send the previously held sample out and keep the new one held. If nothing was held, the tick is an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_load | input | 2 | Per-channel load strobe from the serial side (bit 0 = A) |
| ser_data | input | 40 | Signed 20-bit words, A in [19:0], B in [39:20] |
| tick | input | 2 | Per-channel sample-consume strobe |
| idle_in | input | 2 | Per-channel idle level |
| host_addr | input | 8 | Host register address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational during a read |
| summary | output | 1 | Masked OR of the status byte |
| sample_out | output | 32 | Clipped 16-bit samples, A in [15:0], B in [31:16] |

## Verification
The assertions assume that read and write strobes last one cycle and never arrive together. They also assume that ticks and loads are single-cycle pulses, and that every other input is stable around the clock edge. The bench drives each strobe for exactly one cycle from the falling edge and never overlaps a read with a write. Ticks and loads are also overlapped on purpose, both with each other and with clearing reads, to reach the coincidence cases in R7 and R10.

// File: rtl/txs_pkg.sv
package txs_pkg;

  localparam int unsigned STATUS_W = 8;

  // per-channel view of its three reported flags
  typedef struct packed {
    logic clip;
    logic urun;
    logic idle;
  } chan_flags_t;

  // channel A in the low nibble, B in the high nibble; bits 7 and 3 are zero
  function automatic logic [STATUS_W-1:0] pack_status(input chan_flags_t fa,
                                                      input chan_flags_t fb);
    return {1'b0, fb.clip, fb.urun, fb.idle, 1'b0, fa.clip, fa.urun, fa.idle};
  endfunction

  // mask bits that may actually be stored
  localparam logic [STATUS_W-1:0] MASK_KEEP = 8'h77;

endpackage

// File: rtl/txs_sample_path.sv
module txs_sample_path #(
  parameter int unsigned IN_W  = 20,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IN_W-1:0]  load_data,
  input  logic             tick,
  output logic [OUT_W-1:0] sample,
  output logic             clip_evt,
  output logic             urun_evt,
  output logic             held_valid
);

  localparam logic signed [IN_W-1:0] HI_LIM = IN_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [IN_W-1:0] LO_LIM = ~HI_LIM;

  function automatic logic out_of_range(input logic signed [IN_W-1:0] v);
    return (v > HI_LIM) || (v < LO_LIM);
  endfunction

  function automatic logic [OUT_W-1:0] clip16(input logic signed [IN_W-1:0] v);
    if (v > HI_LIM)      return {1'b0, {(OUT_W-1){1'b1}}};
    else if (v < LO_LIM) return {1'b1, {(OUT_W-1){1'b0}}};
    else                 return v[OUT_W-1:0];
  endfunction

  logic [IN_W-1:0] hold_q;
  logic            hold_v;
  logic            take;

  assign take       = tick & hold_v;
  assign urun_evt   = tick & ~hold_v;
  assign clip_evt   = take & out_of_range(hold_q);
  assign held_valid = hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      sample <= '0;
    end else begin
      if (load) hold_q <= load_data;
      hold_v <= load | (hold_v & ~tick);
      if (take) sample <= clip16(hold_q);
    end
  end

endmodule

// File: rtl/txs_sticky_flags.sv
module txs_sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);

  // a set in the clearing cycle wins so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= set_i | (flag_o & {N{~clr_i}});
  end

endmodule

// File: rtl/txs_status_top.sv
module txs_status_top #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned IN_W      = 20,
  parameter int unsigned OUT_W     = 16,
  parameter logic [7:0]  STAT_ADDR = 8'h10,
  parameter logic [7:0]  MASK_ADDR = 8'h11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ser_load,
  input  logic [2*IN_W-1:0]   ser_data,
  input  logic [1:0]          tick,
  input  logic [1:0]          idle_in,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  output logic                summary,
  output logic [2*OUT_W-1:0]  sample_out
);
  import txs_pkg::*;

  localparam int unsigned NCH = 2;

  logic                 rd_stat;
  logic                 rd_mask;
  logic                 wr_mask;
  logic [NCH-1:0]       clip_evt;
  logic [NCH-1:0]       urun_evt;
  logic [NCH-1:0]       hold_valid;
  logic [STATUS_W-1:0]  stat_vec;
  logic [STATUS_W-1:0]  mask_q;
  chan_flags_t          flags [NCH];

  assign rd_stat = host_rd && (host_addr == ADDR_W'(STAT_ADDR));
  assign rd_mask = host_rd && (host_addr == ADDR_W'(MASK_ADDR));
  assign wr_mask = host_wr && (host_addr == ADDR_W'(MASK_ADDR));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [1:0] sticky;

    txs_sample_path #(.IN_W(IN_W), .OUT_W(OUT_W)) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ser_load[ch]),
      .load_data  (ser_data[ch*IN_W +: IN_W]),
      .tick       (tick[ch]),
      .sample     (sample_out[ch*OUT_W +: OUT_W]),
      .clip_evt   (clip_evt[ch]),
      .urun_evt   (urun_evt[ch]),
      .held_valid (hold_valid[ch])
    );

    txs_sticky_flags #(.N(2)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  ({clip_evt[ch], urun_evt[ch]}),
      .clr_i  (rd_stat),
      .flag_o (sticky)
    );

    assign flags[ch] = '{clip: sticky[1], urun: sticky[0], idle: idle_in[ch]};
  end

  assign stat_vec = pack_status(flags[0], flags[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= host_wdata & MASK_KEEP;
  end

  // mask is write-only: reading its address yields zero
  always_comb begin
    host_rdata = '0;
    if (rd_stat)      host_rdata = stat_vec;
    else if (rd_mask) host_rdata = '0;
  end

  assign summary = |(stat_vec & mask_q);

endmodule

// File: rtl/txs_status_chk.sv
module txs_status_chk #(
  parameter int unsigned OUT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_stat,
  input logic [7:0]         stat_vec,
  input logic [1:0]         clip_evt,
  input logic [1:0]         urun_evt,
  input logic [1:0]         hold_valid,
  input logic [1:0]         tick,
  input logic [2*OUT_W-1:0] sample_out
);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chk
    localparam int CB = ch*4 + 2;
    localparam int UB = ch*4 + 1;

    a_r4_clip_sets: assert property (@(posedge clk) disable iff (!rst_n)
      clip_evt[ch] |=> stat_vec[CB]);

    a_r5_urun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      urun_evt[ch] |=> stat_vec[UB]);

    a_r5_repeat_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[ch] && !hold_valid[ch]) |=> $stable(sample_out[ch*OUT_W +: OUT_W]));

    a_r6_clip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vec[CB] && !rd_stat) |=> stat_vec[CB]);

    a_r6_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vec[UB] && !rd_stat) |=> stat_vec[UB]);

    a_r6_clip_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !clip_evt[ch]) |=> !stat_vec[CB]);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && urun_evt[ch]) |=> stat_vec[UB]);
  end

endmodule

bind txs_status_top txs_status_chk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_stat    (rd_stat),
  .stat_vec   (stat_vec),
  .clip_evt   (clip_evt),
  .urun_evt   (urun_evt),
  .hold_valid (hold_valid),
  .tick       (tick),
  .sample_out (sample_out)
);

// File: tb/test_txs_status_top.sv
module test_txs_status_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ser_load = '0;
  logic [39:0] ser_data = '0;
  logic [1:0]  tick = '0;
  logic [1:0]  idle_in = 2'b11;
  logic [7:0]  host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        summary;
  logic [31:0] sample_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  txs_status_top i_txs_status_top (
    .clk(clk), .rst_n(rst_n), .ser_load(ser_load), .ser_data(ser_data),
    .tick(tick), .idle_in(idle_in), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .summary(summary), .sample_out(sample_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bench model of the 16-bit clip, stated with integers
  function automatic logic [15:0] ref_clip(input int v);
    int r;
    r = (v > 32767) ? 32767 : ((v < -32768) ? -32768 : v);
    return r[15:0];
  endfunction

  task automatic push(input int ch, input int v);
    @(negedge clk);
    ser_load[ch] = 1'b1;
    ser_data[ch*20 +: 20] = v[19:0];
    @(negedge clk);
    ser_load = '0;
  endtask

  task automatic pulse_tick(input int ch);
    @(negedge clk);
    tick[ch] = 1'b1;
    @(negedge clk);
    tick = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr_mask(input logic [7:0] v);
    @(negedge clk);
    host_addr = 8'h11; host_wr = 1'b1; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 summary after reset", summary, 0);
    check("R1 samples after reset", sample_out, 0);
    rd(8'h10, d);
    check("R1 status after reset", d, 8'h11);
  endtask

  task automatic t_idle;
    logic [7:0] d;
    idle_in = 2'b10;
    rd(8'h10, d); check("R8 R2 idle B only", d, 8'h10);
    idle_in = 2'b01;
    rd(8'h10, d); check("R8 R2 idle A only", d, 8'h01);
    idle_in = 2'b00;
    rd(8'h10, d); check("R8 idle dropped", d, 8'h00);
  endtask

  task automatic t_clip;
    logic [7:0] d;
    push(0, 74565); pulse_tick(0);
    check("R3 A high clip", sample_out[15:0], ref_clip(74565));
    rd(8'h10, d); check("R4 R2 A clip flag", d, 8'h04);
    push(0, -40000); pulse_tick(0);
    check("R3 A low clip", sample_out[15:0], ref_clip(-40000));
    rd(8'h10, d); check("R4 A clip flag low", d, 8'h04);
    push(0, 32767); pulse_tick(0);
    check("R3 A at +limit", sample_out[15:0], 16'h7FFF);
    rd(8'h10, d); check("R4 no flag at +limit", d, 8'h00);
    push(0, -32768); pulse_tick(0);
    check("R3 A at -limit", sample_out[15:0], 16'h8000);
    rd(8'h10, d); check("R4 no flag at -limit", d, 8'h00);
    push(0, 1234); pulse_tick(0);
    check("R3 A pass-through", sample_out[15:0], 16'h04D2);
    push(1, 100000); pulse_tick(1);
    check("R3 B high clip", sample_out[31:16], 16'h7FFF);
    check("R3 A untouched by B", sample_out[15:0], 16'h04D2);
    rd(8'h10, d); check("R4 R2 B clip flag", d, 8'h40);
  endtask

  task automatic t_underrun;
    logic [7:0] d;
    pulse_tick(0);
    check("R5 A repeats sample", sample_out[15:0], 16'h04D2);
    check("R9 summary masked off", summary, 0);
    rd(8'h10, d); check("R5 R2 A underrun", d, 8'h02);
    pulse_tick(1);
    check("R5 B repeats sample", sample_out[31:16], 16'h7FFF);
    rd(8'h11, d); check("R9 mask reads zero", d, 8'h00);
    rd(8'h20, d);
    rd(8'h10, d); check("R6 R2 B underrun kept", d, 8'h20);
    rd(8'h10, d); check("R6 cleared by read", d, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    push(0, 50000);
    @(negedge clk);
    tick[0] = 1'b1; host_addr = 8'h10; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    tick = '0; host_rd = 1'b0;
    check("R7 read returns old value", d, 8'h00);
    rd(8'h10, d); check("R7 flag survives clear", d, 8'h04);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    pulse_tick(0);
    check("R9 summary with mask 0", summary, 0);
    wr_mask(8'h02);
    check("R9 summary on urun A", summary, 1);
    wr_mask(8'h88);
    check("R9 reserved mask bits dropped", summary, 0);
    idle_in = 2'b10;
    wr_mask(8'h10);
    check("R9 summary on idle B", summary, 1);
    idle_in = 2'b00;
    #1 check("R9 R8 summary follows idle", summary, 0);
    rd(8'h10, d);
    wr_mask(8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    push(0, 100);
    @(negedge clk);
    ser_load[0] = 1'b1; ser_data[19:0] = 20'd200; tick[0] = 1'b1;
    @(negedge clk);
    ser_load = '0; tick = '0;
    check("R10 old sample out", sample_out[15:0], 16'd100);
    pulse_tick(0);
    check("R10 new sample kept", sample_out[15:0], 16'd200);
    rd(8'h10, d); check("R10 no underrun", d, 8'h00);
    @(negedge clk);
    ser_load[0] = 1'b1; ser_data[19:0] = 20'd300; tick[0] = 1'b1;
    @(negedge clk);
    ser_load = '0; tick = '0;
    check("R10 empty tick repeats", sample_out[15:0], 16'd200);
    rd(8'h10, d); check("R10 empty tick underruns", d, 8'h02);
    pulse_tick(0);
    check("R10 loaded word follows", sample_out[15:0], 16'd300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_clip();
    t_underrun();
    t_collide();
    t_mask();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule